// File: doc/BRIEF.md
# Cascadable Parity Generator and Checker

This block computes parity over a nine-bit data word plus a cascade input, and shares one bidirectional parity line with the other units on a bus. An active-low transmit control picks the mode. While transmitting, the unit drives the line with a parity bit. The bit is chosen so that the word plus the line together hold an odd number of ones. While receiving, the unit releases the line and compares the level on it against its own word. It pulls an active-low error flag when the total count of ones comes out even.

The line is modelled as a tri-state pin with an output enable, an output value and a sampled input. A power-good input, synchronised and held for a set number of cycles, must be valid before the pin can be driven. If power-good drops, the pin is released and the error flag is parked high at once. Longer words are covered by chaining units: each unit XORs a cascade-in value into its tree and presents the running result on a cascade-out. The first unit ties cascade-in low.

Top module: `par_unit`

## Requirements
- R1: `casc_o` equals the XOR of all nine bits of `word_i` and `casc_i` (the running parity), in every mode.
- R2: In transmit mode (`xmit_n_i` = 0) with power valid, `pin_oe_o` is 1 and `pin_out_o` is the inverse of the running parity. It is 1 when the count of ones in `word_i` plus `casc_i` is even.
- R3: While `xmit_n_i` = 0, `err_n_o` is 1 whatever the word and the pin level are.
- R4: While `xmit_n_i` = 1, `pin_oe_o` is 0.
- R5: In receive mode with power valid, `err_n_o` is 0 when the running parity is even and `pin_in_i` is 0.
- R6: In receive mode with power valid, `err_n_o` is 0 when the running parity is odd and `pin_in_i` is 1. In every other receive case, `err_n_o` is 1.
- R7: While `pwr_good_i` is 0, `pin_oe_o` is 0 and `err_n_o` is 1, starting in the same cycle that `pwr_good_i` falls.
- R8: After `pwr_good_i` rises, power becomes valid at rising clock edge SYNC_STAGES+HOLD_CYCLES, counted from the first edge that samples it high. Until then `pin_oe_o` stays 0.
- R9: While `rst_n` is low, `pin_oe_o` is 0 and `err_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the power-hold logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_good_i | input | 1 | Supply-valid indication, active high |
| xmit_n_i | input | 1 | Mode select: 0 transmit (generate), 1 receive (check) |
| word_i | input | WIDTH | Data bits covered by the parity |
| casc_i | input | 1 | Running parity from the previous stage, 0 on the first stage |
| casc_o | output | 1 | Running parity to the next stage |
| pin_in_i | input | 1 | Level sampled from the shared parity line |
| pin_out_o | output | 1 | Value driven onto the line when enabled |
| pin_oe_o | output | 1 | Tri-state enable for the line |
| err_n_o | output | 1 | Parity error, active low |

## Verification
The bench sweeps words with even and odd counts of ones against both line levels in receive mode. A design that swapped the error polarity would flag correct words and pass bad ones. Transmit mode is driven against a line level that would flag an error if checking leaked through. The cascade input is set high, and a tree that ignored it would generate and check the wrong bit. Power-good is toggled to count the exact release edge and to show that the pin is dropped in the same cycle. An off-by-one in the hold counter, or a hold keyed to the registered copy of power-good, would drive the bus early or late.

// File: rtl/par_pkg.sv
package par_pkg;
  typedef enum logic {
    PAR_XMIT = 1'b0,
    PAR_RECV = 1'b1
  } par_mode_e;

  typedef struct packed {
    logic oe;
    logic drive;
    logic err_n;
  } par_pin_t;
endpackage

// File: rtl/par_tree.sv
module par_tree #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic             casc_i,
  output logic             par_o
);
  logic [WIDTH:0] chain;

  assign chain[0] = casc_i;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_fold
      assign chain[g+1] = chain[g] ^ word_i[g];
    end
  endgenerate

  assign par_o = chain[WIDTH];
endmodule

// File: rtl/par_pwr_hold.sv
module par_pwr_hold #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  output logic pwr_ok_o
);
  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [1:0]             rst_sync_q;
  logic                   rst_int_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   ready_q, ready_d;
  logic                   synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_int_n) begin
          if (!rst_int_n) sync_q[0] <= 1'b0;
          else            sync_q[0] <= pwr_good_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_int_n) begin
          if (!rst_int_n) sync_q[g] <= 1'b0;
          else            sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate
  assign synced = sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_d   = cnt_q;
    ready_d = ready_q;
    if (!synced) begin
      cnt_d   = '0;
      ready_d = 1'b0;
    end else if (!ready_q) begin
      if (cnt_q == LAST) ready_d = 1'b1;
      else               cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end

  assign pwr_ok_o = ready_q & pwr_good_i & rst_n;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_int_n)
    cnt_q <= LAST); // R8
  AST_READY_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ready_q) |-> $past(synced)); // R8
endmodule

// File: rtl/par_pin_ctrl.sv
module par_pin_ctrl
  import par_pkg::*;
(
  input  logic     pwr_ok_i,
  input  logic     xmit_n_i,
  input  logic     par_i,
  input  logic     pin_in_i,
  output par_pin_t pin_o
);
  par_mode_e mode;

  assign mode = par_mode_e'(xmit_n_i);

  always_comb begin
    pin_o.oe    = 1'b0;
    pin_o.drive = ~par_i;
    pin_o.err_n = 1'b1;
    if (pwr_ok_i) begin
      unique case (mode)
        PAR_XMIT: pin_o.oe    = 1'b1;
        PAR_RECV: pin_o.err_n = ~(pin_in_i == par_i);
        default:  pin_o.oe    = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/par_unit.sv
module par_unit #(
  parameter int WIDTH       = 9,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good_i,
  input  logic             xmit_n_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             casc_i,
  output logic             casc_o,
  input  logic             pin_in_i,
  output logic             pin_out_o,
  output logic             pin_oe_o,
  output logic             err_n_o
);
  import par_pkg::*;

  logic     par;
  logic     pwr_ok;
  par_pin_t pin;

  par_tree #(.WIDTH(WIDTH)) u_tree (
    .word_i (word_i),
    .casc_i (casc_i),
    .par_o  (par)
  );

  par_pwr_hold #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good_i (pwr_good_i),
    .pwr_ok_o   (pwr_ok)
  );

  par_pin_ctrl u_ctrl (
    .pwr_ok_i (pwr_ok),
    .xmit_n_i (xmit_n_i),
    .par_i    (par),
    .pin_in_i (pin_in_i),
    .pin_o    (pin)
  );

  assign casc_o    = par;
  assign pin_out_o = pin.drive;
  assign pin_oe_o  = pin.oe;
  assign err_n_o   = pin.err_n;

  AST_TX_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !xmit_n_i |-> err_n_o); // R3
  AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_n_i |-> !pin_oe_o); // R4
  AST_OE_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe_o |-> pwr_good_i); // R7
  AST_ERR_QUIET_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_i |-> err_n_o); // R7
  AST_TX_BIT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe_o |-> (pin_out_o != casc_o)); // R2
endmodule

// File: tb/sim_par_unit.sv
`timescale 1ns/1ps
module sim_par_unit;
  localparam int W = 9;
  localparam int SYNC = 2;
  localparam int HOLD = 4;

  logic         clk = 1'b0;
  logic         rst_n, pwr_good, xmit_n, casc_in, bus_ext;
  logic [W-1:0] word;
  logic         casc_out, pin_out, pin_oe, err_n;
  logic         pin_in;
  int           checks = 0;
  int           errors = 0;
  bit           done   = 0;

  always #2 clk = ~clk;

  assign pin_in = pin_oe ? pin_out : bus_ext;

  par_unit #(.WIDTH(W), .SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good_i (pwr_good),
    .xmit_n_i   (xmit_n),
    .word_i     (word),
    .casc_i     (casc_in),
    .casc_o     (casc_out),
    .pin_in_i   (pin_in),
    .pin_out_o  (pin_out),
    .pin_oe_o   (pin_oe),
    .err_n_o    (err_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b word=%h xmit_n=%b bus=%b casc=%b",
               req, act, exp, word, xmit_n, bus_ext, casc_in);
    end
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 37 + (i >> 1) * 101) ^ (i << 5));
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; pwr_good = 1'b1; xmit_n = 1'b0; word = '0;
    casc_in = 1'b0; bus_ext = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 oe", pin_oe, 1'b0);
    chk("R9 err_n", err_n, 1'b1);
    pwr_good = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_power_up();
    xmit_n = 1'b0;
    @(negedge clk); pwr_good = 1'b1;
    repeat (SYNC + HOLD - 1) @(posedge clk);
    #1; chk("R8 early oe", pin_oe, 1'b0);
    @(posedge clk);
    #1; chk("R8 release oe", pin_oe, 1'b1);
  endtask

  task automatic t_transmit(input logic cin);
    @(negedge clk);
    xmit_n = 1'b0; casc_in = cin;
    for (int i = 0; i < 24; i++) begin
      logic p;
      word = pat(i);
      p = (^word) ^ cin;
      bus_ext = p;
      #1;
      chk("R1 casc_o", casc_out, p);
      chk("R2 oe", pin_oe, 1'b1);
      chk("R2 drive", pin_out, ~p);
      chk("R3 err_n", err_n, 1'b1);
      @(negedge clk);
    end
  endtask

  task automatic t_receive(input logic cin);
    @(negedge clk);
    xmit_n = 1'b1; casc_in = cin;
    for (int i = 0; i < 24; i++) begin
      for (int b = 0; b < 2; b++) begin
        logic p;
        word = pat(i);
        bus_ext = b[0];
        p = (^word) ^ cin;
        #1;
        chk("R4 oe", pin_oe, 1'b0);
        chk("R1 casc_o", casc_out, p);
        if (!p) chk("R5 err_n", err_n, b[0]);
        else    chk("R6 err_n", err_n, ~b[0]);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_power_drop();
    @(negedge clk);
    xmit_n = 1'b1; word = 9'h000; casc_in = 1'b0; bus_ext = 1'b0;
    #1; chk("R5 err_n before drop", err_n, 1'b0);
    pwr_good = 1'b0;
    #1; chk("R7 err_n", err_n, 1'b1);
    xmit_n = 1'b0;
    #1; chk("R7 oe", pin_oe, 1'b0);
    repeat (3) @(negedge clk);
    #1; chk("R7 oe held", pin_oe, 1'b0);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_transmit(1'b0);
    t_transmit(1'b1);
    t_receive(1'b0);
    t_receive(1'b1);
    t_power_drop();
    t_power_up();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule